// File: doc/BRIEF.md
# Multichannel Triggered Readout Controller

This block is the digital control core of a multichannel front-end readout chip. It shares one serial data pad, a read/write pad and an externally paced step strobe with an outside controller. While idle, it can take a new configuration word, send the stored one back, or run an acquisition. The configuration word sets the gain code, the analog multiplexer select, two shared DAC codes, a per-channel trigger mask and the readout flavour.

Unmasked channel triggers are latched into a trigger register. A latched trigger drives a shared service-request line, which otherwise floats. While the register holds an event it accepts no new triggers; later hits are dropped, not queued.

Each strobe from the external controller then drives the acquisition forward. The controller walks the channels in ascending order. For each channel it sets the multiplexer, pulses the converter start, and waits for end-of-conversion. It then shifts the result out on the data pad, most significant bit first. In sparse flavour, only latched channels are converted and each result is prefixed by its channel address. In full flavour, every channel is sent with no address. After the last result the request line is released. The trigger register stays frozen until the clear pad returns the block to idle.

Top module: `readout_ctrl`

## Requirements
- R1: After reset the request line is not driven, the data pad is not driven and every configuration field reads zero.
- R2: In idle with no latched trigger, a strobe with `rw_i`=1 starts a write. The next CFG_W strobes each take one bit of `data_i`, MSB first. The word then drives the outputs: bit 21 sparse flag, bits 20:13 channel mask (bit 13+c masks channel c), bits 12:11 gain, bits 10:8 multiplexer select, bits 7:4 reference code, bits 3:0 threshold code.
- R3: In idle with no latched trigger, a strobe with `rw_i`=0 sends the stored word on `data_o`. Transmission is MSB first and advances one bit per strobe.
- R4: A channel trigger that is not masked and arrives while the trigger register is empty is latched. `srq_oe_o` is asserted from the next cycle on.
- R5: While the trigger register holds any bit, further triggers are dropped and never converted.
- R6: `fast_or_o` is the OR of the unmasked trigger inputs. A masked trigger is never latched.
- R7: With the sparse flag set, only latched channels are converted, in ascending order. Each result goes out as a 3-bit channel address followed by 8 data bits, MSB first.
- R8: With the sparse flag clear, all 8 channels are converted in ascending order. Each sends exactly 8 data bits, MSB first.
- R9: Each conversion gets exactly one single-cycle `adc_start_o` pulse, with `mux_sel_o` equal to the channel being converted. The block waits for `adc_eoc_i` before shifting.
- R10: After the last result `srq_oe_o` is released. The trigger register stays frozen, so new triggers do not reassert it until `clear_i` returns the block to idle.
- R11: `data_oe_o` is high only while the configuration is being read or a result is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Clear pad: return to idle, empty trigger register |
| ck_i | input | 1 | One-cycle step strobe from the external controller |
| rw_i | input | 1 | Selects write (1) or read (0) of the configuration |
| data_i | input | 1 | Serial data in |
| data_o | output | 1 | Serial data out |
| data_oe_o | output | 1 | Data pad output enable |
| trig_i | input | N_CH | Channel trigger inputs |
| srq_oe_o | output | 1 | Drives the shared request line active when high |
| fast_or_o | output | 1 | OR of unmasked triggers |
| adc_start_o | output | 1 | Converter start pulse |
| adc_eoc_i | input | 1 | Converter end-of-conversion |
| adc_data_i | input | ADC_W | Converter result |
| mux_sel_o | output | CH_W | Analog multiplexer select |
| gain_o | output | 2 | Shared gain code |
| vref_code_o | output | DAC_W | Reference DAC code |
| ith_code_o | output | DAC_W | Threshold DAC code |

## Verification
The bench builds the block with its defaults: 8 channels, 8-bit results and 4-bit DAC codes, which gives a 22-bit configuration word. These values let it reach both ends of the channel scan. A sparse event uses two non-adjacent channels, with a masked hit and a hit during the freeze. A full readout must step through channel 7 and then release the request line. The 22-bit round trip covers every configuration field, including the mask and the sparse flag at the top of the word.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int GAIN_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_SEL,
    ST_WAIT,
    ST_SHIFT,
    ST_DONE
  } rdo_state_e;
endpackage

// File: rtl/rdo_trig.sv
module rdo_trig #(
  parameter int N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic [N_CH-1:0] trig_i,
  input  logic [N_CH-1:0] mask_i,
  output logic [N_CH-1:0] trig_q_o,
  output logic            fast_or_o
);
  logic [N_CH-1:0] hit;
  logic [N_CH-1:0] trig_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_hit
    assign hit[c] = trig_i[c] & ~mask_i[c];
  end

  assign fast_or_o = |hit;
  assign trig_q_o  = trig_q;

  // capture only while empty; hits during freeze are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              trig_q <= '0;
    else if (clear_i)         trig_q <= '0;
    else if (trig_q == '0)    trig_q <= hit;
  end

  // R5
  trig_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((trig_q != '0) && !clear_i) |=> $stable(trig_q));

  // R6
  mask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q == '0) |=> ((trig_q & $past(mask_i)) == '0));
endmodule

// File: rtl/rdo_shift.sv
module rdo_shift #(
  parameter int W = 22
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= load_val_i;
    else if (shift_i) q_o <= {q_o[W-2:0], ser_i};
  end
endmodule

// File: rtl/readout_ctrl.sv
module readout_ctrl
  import rdo_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int ADC_W = 8,
  parameter int DAC_W = 4,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             ck_i,
  input  logic             rw_i,
  input  logic             data_i,
  output logic             data_o,
  output logic             data_oe_o,
  input  logic [N_CH-1:0]  trig_i,
  output logic             srq_oe_o,
  output logic             fast_or_o,
  output logic             adc_start_o,
  input  logic             adc_eoc_i,
  input  logic [ADC_W-1:0] adc_data_i,
  output logic [CH_W-1:0]  mux_sel_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic [DAC_W-1:0] vref_code_o,
  output logic [DAC_W-1:0] ith_code_o
);
  localparam int ITH_LO  = 0;
  localparam int VREF_LO = DAC_W;
  localparam int MUX_LO  = 2 * DAC_W;
  localparam int GAIN_LO = MUX_LO + CH_W;
  localparam int MASK_LO = GAIN_LO + GAIN_W;
  localparam int SPR_BIT = MASK_LO + N_CH;
  localparam int CFG_W   = SPR_BIT + 1;
  localparam int CNT_W   = $clog2(CFG_W);
  localparam int PAD_S   = CFG_W - CH_W - ADC_W;
  localparam int PAD_F   = CFG_W - ADC_W;

  rdo_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  ch_q;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] sh_q, sh_val;
  logic             sh_load, sh_shift;
  logic [N_CH-1:0]  trig_q;
  logic             any_trig, sparse, ch_hit, ch_last;
  logic [CNT_W-1:0] nbits;

  assign sparse   = cfg_q[SPR_BIT];
  assign any_trig = |trig_q;
  assign ch_hit   = !sparse || trig_q[ch_q];
  assign ch_last  = (ch_q == CH_W'(N_CH - 1));
  assign nbits    = sparse ? CNT_W'(CH_W + ADC_W) : CNT_W'(ADC_W);

  rdo_trig #(.N_CH(N_CH)) u_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .trig_i   (trig_i),
    .mask_i   (cfg_q[MASK_LO +: N_CH]),
    .trig_q_o (trig_q),
    .fast_or_o(fast_or_o)
  );

  rdo_shift #(.W(CFG_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sh_load),
    .load_val_i(sh_val),
    .shift_i   (sh_shift),
    .ser_i     (data_i),
    .q_o       (sh_q)
  );

  always_comb begin
    sh_load     = 1'b0;
    sh_shift    = 1'b0;
    sh_val      = cfg_q;
    adc_start_o = 1'b0;
    unique case (state_q)
      ST_IDLE:  sh_load  = ck_i && !any_trig && !rw_i && !clear_i;
      ST_WR,
      ST_RD,
      ST_SHIFT: sh_shift = ck_i && !clear_i;
      ST_SEL:   adc_start_o = ch_hit && !clear_i;
      ST_WAIT: begin
        sh_load = adc_eoc_i && !clear_i;
        sh_val  = sparse ? {ch_q, adc_data_i, {PAD_S{1'b0}}}
                         : {adc_data_i, {PAD_F{1'b0}}};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
      cfg_q   <= '0;
    end else if (clear_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (ck_i) begin
          cnt_q <= '0;
          ch_q  <= '0;
          if (any_trig)  state_q <= ST_SEL;
          else if (rw_i) state_q <= ST_WR;
          else           state_q <= ST_RD;
        end
        ST_WR: if (ck_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(CFG_W - 1)) begin
            cfg_q   <= {sh_q[CFG_W-2:0], data_i};
            state_q <= ST_IDLE;
          end
        end
        ST_RD: if (ck_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(CFG_W - 1)) state_q <= ST_IDLE;
        end
        ST_SEL: begin
          if (ch_hit)       state_q <= ST_WAIT;
          else if (ch_last) state_q <= ST_DONE;
          else              ch_q    <= ch_q + 1'b1;
        end
        ST_WAIT: if (adc_eoc_i) begin
          state_q <= ST_SHIFT;
          cnt_q   <= '0;
        end
        ST_SHIFT: if (ck_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == nbits - 1'b1) begin
            cnt_q <= '0;
            if (ch_last) state_q <= ST_DONE;
            else begin
              ch_q    <= ch_q + 1'b1;
              state_q <= ST_SEL;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign srq_oe_o    = any_trig && (state_q != ST_DONE);
  assign data_oe_o   = (state_q == ST_RD) || (state_q == ST_SHIFT);
  assign data_o      = sh_q[CFG_W-1] & data_oe_o;
  assign mux_sel_o   = (state_q inside {ST_SEL, ST_WAIT, ST_SHIFT}) ? ch_q
                                                                    : cfg_q[MUX_LO +: CH_W];
  assign gain_o      = cfg_q[GAIN_LO +: GAIN_W];
  assign vref_code_o = cfg_q[VREF_LO +: DAC_W];
  assign ith_code_o  = cfg_q[ITH_LO +: DAC_W];

  // R9
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  // R7
  start_sparse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> (!sparse || trig_q[mux_sel_o]));

  // R9
  eoc_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && !adc_eoc_i && !clear_i) |=> !data_oe_o);

  // R10
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_DONE) && !clear_i) |=> !srq_oe_o);
endmodule

// File: tb/readout_ctrl_tb_top.sv
module readout_ctrl_tb_top;
  localparam int N_CH = 8, ADC_W = 8, DAC_W = 4, CH_W = 3, CFG_W = 22;

  logic clk = 1'b0, rst_ni = 1'b0, clear_i = 1'b0, ck_i = 1'b0, rw_i = 1'b0, data_i = 1'b0;
  logic data_o, data_oe_o, srq_oe_o, fast_or_o, adc_start_o;
  logic adc_eoc_i = 1'b0;
  logic [ADC_W-1:0] adc_data_i = '0;
  logic [N_CH-1:0] trig_i = '0;
  logic [CH_W-1:0] mux_sel_o;
  logic [1:0] gain_o;
  logic [DAC_W-1:0] vref_code_o, ith_code_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  bit exp_q[$];
  int start_log[$];
  int adc_cnt = 0;
  logic [CH_W-1:0] adc_ch = '0;

  always #2.5 clk = ~clk;

  readout_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .ck_i(ck_i), .rw_i(rw_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o), .trig_i(trig_i),
    .srq_oe_o(srq_oe_o), .fast_or_o(fast_or_o), .adc_start_o(adc_start_o),
    .adc_eoc_i(adc_eoc_i), .adc_data_i(adc_data_i), .mux_sel_o(mux_sel_o),
    .gain_o(gain_o), .vref_code_o(vref_code_o), .ith_code_o(ith_code_o)
  );

  function automatic logic [7:0] adc_code(input int ch);
    return 8'(8'h3C + ch * 23);
  endfunction

  // converter model: eoc three cycles after start
  always @(posedge clk) begin
    adc_eoc_i <= 1'b0;
    if (adc_start_o) begin
      adc_cnt <= 3;
      adc_ch  <= mux_sel_o;
      start_log.push_back(int'(mux_sel_o));
    end else if (adc_cnt != 0) begin
      adc_cnt <= adc_cnt - 1;
      if (adc_cnt == 1) begin
        adc_eoc_i  <= 1'b1;
        adc_data_i <= adc_code(int'(adc_ch));
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) ck_i = 1'b1;
    @(negedge clk) ck_i = 1'b0;
  endtask

  task automatic push_bits(input int val, input int n);
    for (int i = n - 1; i >= 0; i--) exp_q.push_back(val[i]);
  endtask

  // monitor: pop expected bits and compare while the pad is driven
  task automatic drain(input string req);
    while (exp_q.size() != 0) begin
      bit e;
      while (!data_oe_o) @(negedge clk);
      e = exp_q.pop_front();
      check(data_o == e, req, data_o, e);
      tick();
    end
  endtask

  task automatic wr_cfg(input logic [CFG_W-1:0] v);
    @(negedge clk) rw_i = 1'b1;
    tick();
    rw_i = 1'b0;
    for (int i = CFG_W - 1; i >= 0; i--) begin
      data_i = v[i];
      tick();
    end
    data_i = 1'b0;
  endtask

  initial begin
    logic [CFG_W-1:0] cfg1, cfg2;
    cfg1 = {1'b1, 8'h80, 2'b10, 3'd6, 4'hA, 4'h3};
    cfg2 = {1'b0, 8'h00, 2'b01, 3'd2, 4'h5, 4'hC};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(srq_oe_o == 0, "R1", srq_oe_o, 0);
    check(data_oe_o == 0, "R1", data_oe_o, 0);
    check({gain_o, vref_code_o, ith_code_o} == 0, "R1", {gain_o, vref_code_o, ith_code_o}, 0);

    wr_cfg(cfg1);
    check(gain_o == 2'b10, "R2", gain_o, 2);
    check(vref_code_o == 4'hA, "R2", vref_code_o, 10);
    check(ith_code_o == 4'h3, "R2", ith_code_o, 3);
    check(mux_sel_o == 3'd6, "R2", mux_sel_o, 6);
    check(data_oe_o == 0, "R11", data_oe_o, 0);

    // R3 read back
    tick();
    push_bits(int'(cfg1), CFG_W);
    drain("R3");
    @(negedge clk);
    check(data_oe_o == 0, "R11", data_oe_o, 0);

    // R6 masked hit on channel 7
    trig_i = 8'h80;
    @(negedge clk);
    check(fast_or_o == 0, "R6", fast_or_o, 0);
    trig_i = 8'h00;
    @(negedge clk);
    check(srq_oe_o == 0, "R6", srq_oe_o, 0);

    // R4 hits on channels 2 and 5
    trig_i = 8'h24;
    #1 check(fast_or_o == 1, "R6", fast_or_o, 1);
    @(negedge clk);
    trig_i = 8'h00;
    check(srq_oe_o == 1, "R4", srq_oe_o, 1);

    // R5 hit on channel 1 during freeze
    trig_i = 8'h02;
    @(negedge clk);
    trig_i = 8'h00;

    // R7 sparse readout
    start_log.delete();
    tick();
    push_bits(2, 3); push_bits(int'(adc_code(2)), 8);
    push_bits(5, 3); push_bits(int'(adc_code(5)), 8);
    drain("R7");
    repeat (3) @(negedge clk);
    check(start_log.size() == 2, "R9", start_log.size(), 2);
    if (start_log.size() == 2) begin
      check(start_log[0] == 2, "R9", start_log[0], 2);
      check(start_log[1] == 5, "R5", start_log[1], 5);
    end
    check(srq_oe_o == 0, "R10", srq_oe_o, 0);
    trig_i = 8'h01;
    @(negedge clk);
    trig_i = 8'h00;
    @(negedge clk);
    check(srq_oe_o == 0, "R10", srq_oe_o, 0);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    @(negedge clk);
    check(srq_oe_o == 0, "R10", srq_oe_o, 0);

    // R8 full readout
    wr_cfg(cfg2);
    check(gain_o == 2'b01, "R2", gain_o, 1);
    trig_i = 8'h08;
    @(negedge clk);
    trig_i = 8'h00;
    check(srq_oe_o == 1, "R4", srq_oe_o, 1);
    start_log.delete();
    tick();
    for (int c = 0; c < N_CH; c++) push_bits(int'(adc_code(c)), 8);
    drain("R8");
    repeat (3) @(negedge clk);
    check(start_log.size() == N_CH, "R9", start_log.size(), N_CH);
    for (int c = 0; c < start_log.size(); c++)
      check(start_log[c] == c, "R9", start_log[c], c);
    check(srq_oe_o == 0, "R10", srq_oe_o, 0);
    check(data_oe_o == 0, "R11", data_oe_o, 0);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule